// File: doc/BRIEF.md
# Bus Cycle Wait-State and Ready Sequencer

This block paces one bus cycle at a time. A start pulse launches a cycle that steps through three fixed phases (T1, T2, T3), then through zero or more wait clocks (TW), and ends in T4. The number of wait clocks comes from the wait code of the region the cycle hits. When that region demands an external handshake, the cycle can also be held in TW until a ready input is seen.

Region configuration arrives already resolved. It consists of a wait code, a flag saying whether the code uses the extended 3-bit meaning, a ready-required flag, and a flag marking a hit on the on-chip control block. A select pin chooses the ready source. One source is an asynchronous ready, which passes through a two-flop synchroniser. The other is a synchronous ready, which is used as sampled. The outputs are plain control pins: a phase code for every clock, a wait indicator and a one-clock done pulse. There is no data stream and no back-pressure.

The ready input is sampled at one point in the cycle. That point is the first wait clock, or T3 when no waits are programmed. Programmed waits always run out in full. When ready is missed at the sample point, the cycle stays in TW until ready is seen. One further TW follows before T4.

Top module: `wsq_top`

## Requirements
- R1: While rst_n is low and after reset, bus_phase is 0 (idle), and wait_ins and cyc_done are 0.
- R2: A cyc_start high on a clock where bus_phase is idle starts a cycle. The phase codes that follow are 1 (T1), 2 (T2) and 3 (T3). cyc_start is ignored in every other phase, even when held high.
- R3: With wait_wide=0, the number of wait clocks equals wait_code[1:0], and wait_code[2] has no effect.
- R4: With wait_wide=1, wait codes 0 to 3 give 0 to 3 wait clocks, and codes 4, 5, 6 and 7 give 5, 7, 9 and 15 wait clocks.
- R5: With rdy_req=0, a cycle lasts exactly 4 plus N clocks (N is the decoded wait count), whatever the ready inputs do.
- R6: With rdy_req=1, ready is sampled in the first TW clock, or in T3 when N is 0. If ready is seen there, the cycle lasts 4 plus N clocks.
- R7: If ready is not seen at the sample point, the cycle stays in TW until ready is seen. At least one more TW clock follows before T4, and all programmed waits still complete. The last TW is clock max(3+N, r+1), where r is the clock index in which ready is seen (T1 is index 1).
- R8: rdy_src_sync=1 selects rdy_sync, used in the clock it is high. rdy_src_sync=0 selects rdy_async through a two-flop synchroniser, so a level applied during clock a counts from clock a+2. The unselected input has no effect.
- R9: With pcb_hit=1, the cycle has zero waits and ignores ready, lasting 4 clocks whatever the wait code and rdy_req.
- R10: cyc_done is high for exactly the single T4 clock (phase code 5), and the next clock is idle. wait_ins is high exactly in TW clocks (phase code 4).
- R11: The region configuration is captured when the cycle starts. Changes to it during the cycle do not alter that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_start | input | 1 | Request to start a bus cycle |
| wait_code | input | 3 | Wait code of the addressed region |
| wait_wide | input | 1 | 1: the code uses the extended 3-bit meaning |
| rdy_req | input | 1 | 1: external ready is required |
| pcb_hit | input | 1 | Cycle targets the on-chip control block |
| rdy_src_sync | input | 1 | 1: use rdy_sync, 0: use rdy_async |
| rdy_async | input | 1 | Asynchronous ready input |
| rdy_sync | input | 1 | Synchronous ready input |
| bus_phase | output | 3 | 0 idle, 1 T1, 2 T2, 3 T3, 4 TW, 5 T4 |
| wait_ins | output | 1 | High during wait clocks |
| cyc_done | output | 1 | One-clock pulse in T4 |

## Verification
A wrong wait counter or a wrong decode shows up at once as a cycle of the wrong length. The bench therefore measures every cycle from T1 to the done pulse and compares the length with a count it derives from the requirements. A wrong ready flag shows within one clock of the sample point: the cycle either leaves TW too early or stays too long, or the extra wait after a late ready is missing. A fault in the synchroniser depth or in the source selection shifts the end of a late-ready cycle by one or more clocks. Driving the unselected ready input to the opposite level exposes a source that was not isolated.

// File: rtl/wsq_pkg.sv
package wsq_pkg;
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_T1   = 3'd1,
    PH_T2   = 3'd2,
    PH_T3   = 3'd3,
    PH_TW   = 3'd4,
    PH_T4   = 3'd5
  } phase_e;
endpackage

// File: rtl/wsq_wait_decode.sv
module wsq_wait_decode #(
  parameter int CNT_W = 4
) (
  input  logic [2:0]       code,
  input  logic             wide,
  output logic [CNT_W-1:0] waits
);
  always_comb begin
    if (wide && code[2]) begin
      case (code[1:0])
        2'd0:    waits = CNT_W'(5);
        2'd1:    waits = CNT_W'(7);
        2'd2:    waits = CNT_W'(9);
        default: waits = CNT_W'(15);
      endcase
    end else begin
      waits = CNT_W'(code[1:0]);
    end
  end
endmodule

// File: rtl/wsq_sync.sv
module wsq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-2:0], d};
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/wsq_fsm.sv
module wsq_fsm
  import wsq_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] waits_in,
  input  logic             need_in,
  input  logic             rdy,
  output phase_e           phase
);
  phase_e           ph, ph_n;
  logic [CNT_W-1:0] cnt, cnt_n;
  logic             need_q, need_n;
  logic             first_q, first_n;
  logic             got_q, got_n;

  always_comb begin
    ph_n    = ph;
    cnt_n   = cnt;
    need_n  = need_q;
    first_n = first_q;
    got_n   = got_q;
    case (ph)
      PH_IDLE: begin
        if (start) begin
          ph_n    = PH_T1;
          cnt_n   = waits_in;
          need_n  = need_in;
          got_n   = 1'b0;
          first_n = 1'b0;
        end
      end
      PH_T1: ph_n = PH_T2;
      PH_T2: ph_n = PH_T3;
      PH_T3: begin
        if (cnt != '0) begin
          ph_n    = PH_TW;
          first_n = 1'b1;
        end else if (!need_q || rdy) begin
          ph_n  = PH_T4;
          got_n = 1'b1;
        end else begin
          ph_n    = PH_TW;
          first_n = 1'b0;
        end
      end
      PH_TW: begin
        first_n = 1'b0;
        if (need_q && !got_q) begin
          if (rdy) begin
            got_n = 1'b1;
            if (first_q) begin
              if (cnt <= CNT_W'(1)) ph_n = PH_T4;
              else                  cnt_n = cnt - CNT_W'(1);
            end else begin
              cnt_n = (cnt > CNT_W'(1)) ? cnt - CNT_W'(1) : CNT_W'(1);
            end
          end else begin
            cnt_n = (cnt == '0) ? '0 : cnt - CNT_W'(1);
          end
        end else begin
          if (cnt <= CNT_W'(1)) ph_n = PH_T4;
          else                  cnt_n = cnt - CNT_W'(1);
        end
      end
      PH_T4:   ph_n = PH_IDLE;
      default: ph_n = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph      <= PH_IDLE;
      cnt     <= '0;
      need_q  <= 1'b0;
      first_q <= 1'b0;
      got_q   <= 1'b0;
    end else begin
      ph      <= ph_n;
      cnt     <= cnt_n;
      need_q  <= need_n;
      first_q <= first_n;
      got_q   <= got_n;
    end
  end

  assign phase = ph;

  AST_T1_ONLY_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_T1) |-> ($past(ph) == PH_IDLE)); // R2
  AST_PROG_WAITS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_TW && cnt > CNT_W'(1)) |=> (ph == PH_TW)); // R7
  AST_HOLD_WITHOUT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_TW && need_q && !got_q && !rdy) |=> (ph == PH_TW)); // R7
  AST_LATE_READY_EXTRA: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_TW && need_q && !got_q && !first_q && rdy) |=> (ph == PH_TW)); // R7
  AST_NO_NEED_NO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_T3 && !need_q && cnt == '0) |=> (ph == PH_T4)); // R5
  AST_T4_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_T4) |=> (ph == PH_IDLE)); // R10
endmodule

// File: rtl/wsq_top.sv
module wsq_top
  import wsq_pkg::*;
#(
  parameter int CNT_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cyc_start,
  input  logic [2:0] wait_code,
  input  logic       wait_wide,
  input  logic       rdy_req,
  input  logic       pcb_hit,
  input  logic       rdy_src_sync,
  input  logic       rdy_async,
  input  logic       rdy_sync,
  output logic [2:0] bus_phase,
  output logic       wait_ins,
  output logic       cyc_done
);
  logic [CNT_W-1:0] dec_waits;
  logic [CNT_W-1:0] eff_waits;
  logic             async_s;
  logic             rdy_eff;
  logic             need;
  phase_e           phase;

  wsq_wait_decode #(.CNT_W(CNT_W)) u_dec (
    .code  (wait_code),
    .wide  (wait_wide),
    .waits (dec_waits)
  );

  wsq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (rdy_async),
    .q     (async_s)
  );

  assign rdy_eff   = rdy_src_sync ? rdy_sync : async_s;
  assign need      = rdy_req && !pcb_hit;
  assign eff_waits = pcb_hit ? '0 : dec_waits;

  wsq_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (cyc_start),
    .waits_in (eff_waits),
    .need_in  (need),
    .rdy      (rdy_eff),
    .phase    (phase)
  );

  assign bus_phase = phase;
  assign wait_ins  = (phase == PH_TW);
  assign cyc_done  = (phase == PH_T4);

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_done |=> !cyc_done); // R10
  AST_WAIT_NOT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !(wait_ins && cyc_done)); // R10
endmodule

// File: tb/wsq_top_bench.sv
module wsq_top_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cyc_start;
  logic [2:0] wait_code;
  logic       wait_wide;
  logic       rdy_req;
  logic       pcb_hit;
  logic       rdy_src_sync;
  logic       rdy_async;
  logic       rdy_sync;
  logic [2:0] bus_phase;
  logic       wait_ins;
  logic       cyc_done;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  wsq_top u_wsq_top (
    .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .wait_code(wait_code),
    .wait_wide(wait_wide), .rdy_req(rdy_req), .pcb_hit(pcb_hit),
    .rdy_src_sync(rdy_src_sync), .rdy_async(rdy_async), .rdy_sync(rdy_sync),
    .bus_phase(bus_phase), .wait_ins(wait_ins), .cyc_done(cyc_done)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_waits(input logic [2:0] code, input logic wide, input logic pcb);
    if (pcb) return 0;
    if (wide && code[2]) begin
      case (code[1:0])
        2'd0: return 5;
        2'd1: return 7;
        2'd2: return 9;
        default: return 15;
      endcase
    end
    return int'(code[1:0]);
  endfunction

  function automatic int exp_len(input int n, input logic need, input int rdy_at);
    int s;
    int last;
    if (!need) return 4 + n;
    s = (n == 0) ? 3 : 4;
    if (rdy_at <= s) return 4 + n;
    last = (3 + n > rdy_at + 1) ? 3 + n : rdy_at + 1;
    return last + 1;
  endfunction

  function automatic logic sel_lvl(input int idx, input int rdy_at, input logic sel, input logic is_sync);
    logic a;
    logic s;
    s = (idx >= rdy_at);
    a = (idx >= rdy_at - 2);
    if (is_sync) return sel ? s : !s;
    return sel ? !a : a;
  endfunction

  // One bus cycle; length, phase order, wait flag and done pulse are checked.
  task automatic run_cycle(input string tag, input logic [2:0] code, input logic wide,
                           input logic req, input logic pcb, input logic sel,
                           input int rdy_at, input logic hold, input logic scramble);
    int len;
    int tw;
    int exp;
    len = 0;
    tw  = 0;
    exp = exp_len(exp_waits(code, wide, pcb), req && !pcb, rdy_at);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      cyc_start = 1'b0;
      rdy_sync  = sel_lvl(0, rdy_at, sel, 1'b1);
      rdy_async = sel_lvl(0, rdy_at, sel, 1'b0);
    end
    @(negedge clk);
    cyc_start = 1'b1;
    wait_code = code; wait_wide = wide; rdy_req = req; pcb_hit = pcb; rdy_src_sync = sel;
    for (int idx = 1; idx <= 40; idx++) begin
      @(negedge clk);
      if (!hold) cyc_start = 1'b0;
      if (scramble) begin
        wait_code = ~code; wait_wide = ~wide; rdy_req = ~req; pcb_hit = ~pcb;
      end
      rdy_sync  = sel_lvl(idx, rdy_at, sel, 1'b1);
      rdy_async = sel_lvl(idx, rdy_at, sel, 1'b0);
      #1;
      if (idx <= 3) chk({tag, " R2 phase order"}, int'(bus_phase), idx);
      chk({tag, " R10 wait flag"}, int'(wait_ins), int'(bus_phase == 3'd4));
      if (wait_ins) tw++;
      if (cyc_done) begin
        len = idx;
        chk({tag, " R10 done in T4"}, int'(bus_phase), 5);
        break;
      end
    end
    chk({tag, " cycle length"}, len, exp);
    chk({tag, " wait clocks"}, tw, exp - 4);
    @(negedge clk);
    #1;
    chk({tag, " R10 idle after T4"}, int'(bus_phase), 0);
    chk({tag, " R10 single done"}, int'(cyc_done), 0);
    cyc_start = 1'b0;
    wait_code = code; wait_wide = wide; rdy_req = req; pcb_hit = pcb;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 phase", int'(bus_phase), 0);
    chk("R1 wait", int'(wait_ins), 0);
    chk("R1 done", int'(cyc_done), 0);
  endtask

  task automatic t_narrow;
    for (int c = 0; c < 8; c++)
      run_cycle("R3 R5 narrow", 3'(c), 1'b0, 1'b0, 1'b0, 1'b1, 100, 1'b0, 1'b0);
  endtask

  task automatic t_wide;
    for (int c = 0; c < 8; c++)
      run_cycle("R4 wide", 3'(c), 1'b1, 1'b0, 1'b0, 1'b1, 100, 1'b0, 1'b0);
  endtask

  task automatic t_ready_on_time;
    run_cycle("R6 n2 ready early", 3'd2, 1'b0, 1'b1, 1'b0, 1'b1, 1, 1'b0, 1'b0);
    run_cycle("R6 n2 ready at TW1", 3'd2, 1'b0, 1'b1, 1'b0, 1'b1, 4, 1'b0, 1'b0);
    run_cycle("R6 n0 ready at T3", 3'd0, 1'b0, 1'b1, 1'b0, 1'b1, 3, 1'b0, 1'b0);
  endtask

  task automatic t_ready_late;
    run_cycle("R7 n2 late", 3'd2, 1'b0, 1'b1, 1'b0, 1'b1, 5, 1'b0, 1'b0);
    run_cycle("R7 n2 very late", 3'd2, 1'b0, 1'b1, 1'b0, 1'b1, 9, 1'b0, 1'b0);
    run_cycle("R7 n0 late", 3'd0, 1'b0, 1'b1, 1'b0, 1'b1, 6, 1'b0, 1'b0);
    run_cycle("R7 n3 late", 3'd3, 1'b0, 1'b1, 1'b0, 1'b1, 5, 1'b0, 1'b0);
    run_cycle("R7 n15 late", 3'd7, 1'b1, 1'b1, 1'b0, 1'b1, 6, 1'b0, 1'b0);
  endtask

  task automatic t_no_ready_needed;
    run_cycle("R5 ready never", 3'd3, 1'b0, 1'b0, 1'b0, 1'b1, 100, 1'b0, 1'b0);
    run_cycle("R5 async never", 3'd5, 1'b1, 1'b0, 1'b0, 1'b0, 100, 1'b0, 1'b0);
  endtask

  task automatic t_async_source;
    run_cycle("R8 async late", 3'd1, 1'b0, 1'b1, 1'b0, 1'b0, 7, 1'b0, 1'b0);
    run_cycle("R8 async on time", 3'd1, 1'b0, 1'b1, 1'b0, 1'b0, 4, 1'b0, 1'b0);
    run_cycle("R8 sync late decoy", 3'd1, 1'b0, 1'b1, 1'b0, 1'b1, 8, 1'b0, 1'b0);
  endtask

  task automatic t_pcb;
    run_cycle("R9 pcb", 3'd7, 1'b1, 1'b1, 1'b1, 1'b1, 100, 1'b0, 1'b0);
  endtask

  task automatic t_hold_start;
    run_cycle("R2 start held", 3'd1, 1'b0, 1'b0, 1'b0, 1'b1, 100, 1'b1, 1'b0);
  endtask

  task automatic t_scramble;
    run_cycle("R11 config change", 3'd3, 1'b0, 1'b0, 1'b0, 1'b1, 100, 1'b0, 1'b1);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cycles, 100000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    cyc_start = 1'b0; wait_code = '0; wait_wide = 1'b0; rdy_req = 1'b0;
    pcb_hit = 1'b0; rdy_src_sync = 1'b1; rdy_async = 1'b0; rdy_sync = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 phase in reset", int'(bus_phase), 0);
    rst_n = 1'b1;
    t_reset();
    t_narrow();
    t_wide();
    t_ready_on_time();
    t_ready_late();
    t_no_ready_needed();
    t_async_source();
    t_pcb();
    t_hold_start();
    t_scramble();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule